// File: doc/BRIEF.md
# Walking-Address Static RAM Test Sequencer

This block drives an external 8K x 8 asynchronous static RAM through its 13-bit address bus, a split bidirectional data bus (output value, output enable, input value), two chip selects, a write strobe and an output-enable strobe. A pulse on `start` runs a fixed test program. The program first walks the address lines with a single set bit, reading each location back and overwriting it at once so that aliased address lines show up. It then checks that each chip select blocks writes, and finally toggles every data line on its own at address zero.

Each read is compared against the value the program expects. The first mismatch stops the run and latches the phase code, the address, the expected byte and the received byte. A clean run ends with `done` and `pass` high. All bus phases have a programmable length in clock cycles (`PHASE_CYC`), so that address setup, strobe width and data sampling can be matched to the access time of the RAM.

Top module: `srw_walk_tester`

## Requirements
- R1: Phase code 0 writes 0x55 to fourteen addresses in this order: address zero, then bit 0 set, then bit 1 set, and so on up to bit 12 set. The chip is selected (`mem_sel_hi`=1, `mem_sel_lo_n`=0).
- R2: Phase code 1 visits the same fourteen addresses in the same order. At each address it reads and expects 0x55, then writes 0xAA to that address before it moves on.
- R3: Phase code 2 reads the fourteen addresses in the same order and expects 0xAA at each.
- R4: Phase code 3 writes 0xAA to address 0 while selected. It then writes 0x55 to address 0 with both selects high (`mem_sel_hi`=1, `mem_sel_lo_n`=1), which the RAM must ignore. It then reads address 0 while selected and expects 0xAA.
- R5: Phase code 4 writes 0x55 to address 0 while selected. It then writes 0xAA with both selects low (`mem_sel_hi`=0, `mem_sel_lo_n`=0), which the RAM must ignore. It then reads address 0 while selected and expects 0x55.
- R6: Phase code 5 handles data bits 0 to 7 in order. For each bit b it writes ~(1<<b) to address 0 and reads it back, then writes (1<<b) and reads it back, expecting the written value each time.
- R7: Each access takes three bus phases of `PHASE_CYC` cycles each: setup, strobe and hold. In a write, the data is driven in all three phases and `mem_we_n` is low for exactly the strobe phase. In a read, `mem_oe_n` is low for the strobe phase, and the data is sampled on the last cycle of that phase.
- R8: `mem_dq_oe` is high only during write accesses. It is never high while `mem_oe_n` is low, and it is low in the cycle before any fall of `mem_oe_n`.
- R9: On the first mismatch the run stops and `done` and `fail` rise. `fail_phase`, `fail_addr`, `fail_exp` and `fail_got` hold the phase code, the address, the expected byte and the received byte until the next accepted start.
- R10: When every access matches, the run ends after the last read of phase 5 with `done`=1, `pass`=1 and `fail`=0.
- R11: After reset the block is idle. Both strobes are high, `mem_dq_oe`=0, the chip is deselected (`mem_sel_hi`=0, `mem_sel_lo_n`=1), and `done`, `pass` and `fail` are 0. A `start` pulse while idle clears the results and begins at phase 0. A `start` pulse during a run is ignored.
- R12: `mem_addr` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test run when idle |
| mem_addr | output | ADDR_W | RAM address |
| mem_dq_out | output | DATA_W | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data bus drivers |
| mem_dq_in | input | DATA_W | Data received from the RAM |
| mem_sel_hi | output | 1 | Active-high chip select |
| mem_sel_lo_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| done | output | 1 | Run finished, by pass or by fail |
| pass | output | 1 | Run finished with no mismatch |
| fail | output | 1 | Run stopped on a mismatch |
| fail_phase | output | 3 | Phase code of the failing read |
| fail_addr | output | ADDR_W | Address of the failing read |
| fail_exp | output | DATA_W | Expected byte |
| fail_got | output | DATA_W | Received byte |

## Verification
The bench attaches a RAM model with switchable faults. Ignoring address bit 5 makes location 0x0020 alias address zero, so a design that did not overwrite each address right after reading it would miss the fault; the correct design fails in phase 1 at 0x0020 with 0xAA received. Stuck-at-one on data bit 3 and stuck-at-zero on bit 7 check that the latched phase, address and bytes point at the first bad read rather than a later one. A model that ignores the active-low select catches a design that let a deselected write pass, or that drove the wrong select pair. A `start` pulse in the middle of a run checks that a design which restarted on it would be caught by the sequence of accesses the scoreboard expects.

// File: rtl/srw_pkg.sv
package srw_pkg;
  typedef enum logic [2:0] {
    PH_WALK_WR = 3'd0,
    PH_WALK_RW = 3'd1,
    PH_WALK_RD = 3'd2,
    PH_CS_HI   = 3'd3,
    PH_CS_LO   = 3'd4,
    PH_BITS    = 3'd5
  } srw_phase_e;

  typedef enum logic [1:0] {
    SEL_ON     = 2'd0,
    SEL_OFF_HI = 2'd1,
    SEL_OFF_LO = 2'd2
  } srw_sel_e;

  typedef enum logic [1:0] {
    BP_SETUP  = 2'd0,
    BP_STROBE = 2'd1,
    BP_HOLD   = 2'd2
  } srw_bus_e;
endpackage

// File: rtl/srw_step_rom.sv
module srw_step_rom
  import srw_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 5
) (
  input  srw_phase_e          phase,
  input  logic [IDX_W-1:0]    idx,
  output logic                is_wr,
  output logic [ADDR_W-1:0]   addr,
  output logic [DATA_W-1:0]   data,
  output srw_sel_e            sel,
  output logic                last
);
  localparam int N_WALK = ADDR_W + 1;

  function automatic logic [DATA_W-1:0] pat_a();
    logic [DATA_W-1:0] p;
    for (int i = 0; i < DATA_W; i++) p[i] = ~i[0];
    return p;
  endfunction

  localparam logic [DATA_W-1:0] PAT_A = pat_a();
  localparam logic [DATA_W-1:0] PAT_B = ~PAT_A;

  function automatic logic [ADDR_W-1:0] walk_addr(input int k);
    if (k == 0) return '0;
    return ADDR_W'(1) << (k - 1);
  endfunction

  logic [DATA_W-1:0] one_hot;

  always_comb begin
    is_wr   = 1'b0;
    addr    = '0;
    data    = PAT_A;
    sel     = SEL_ON;
    last    = 1'b0;
    one_hot = DATA_W'(1) << int'(idx >> 2);
    unique case (phase)
      PH_WALK_WR: begin
        is_wr = 1'b1;
        addr  = walk_addr(int'(idx));
        last  = (int'(idx) == N_WALK - 1);
      end
      PH_WALK_RW: begin
        addr  = walk_addr(int'(idx >> 1));
        is_wr = idx[0];
        data  = idx[0] ? PAT_B : PAT_A;
        last  = (int'(idx) == 2 * N_WALK - 1);
      end
      PH_WALK_RD: begin
        addr  = walk_addr(int'(idx));
        data  = PAT_B;
        last  = (int'(idx) == N_WALK - 1);
      end
      PH_CS_HI: begin
        is_wr = (int'(idx) < 2);
        data  = (int'(idx) == 1) ? PAT_A : PAT_B;
        sel   = (int'(idx) == 1) ? SEL_OFF_HI : SEL_ON;
        last  = (int'(idx) == 2);
      end
      PH_CS_LO: begin
        is_wr = (int'(idx) < 2);
        data  = (int'(idx) == 1) ? PAT_B : PAT_A;
        sel   = (int'(idx) == 1) ? SEL_OFF_LO : SEL_ON;
        last  = (int'(idx) == 2);
      end
      default: begin
        is_wr = ~idx[0];
        data  = idx[1] ? one_hot : ~one_hot;
        last  = (int'(idx) == 4 * DATA_W - 1);
      end
    endcase
  end
endmodule

// File: rtl/srw_bus_engine.sv
module srw_bus_engine
  import srw_pkg::*;
#(
  parameter int PHASE_CYC = 2,
  parameter int CNT_W     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic is_wr,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe,
  output logic sample,
  output logic step_end
);
  srw_bus_e          bp;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_last;

  assign cnt_last = (cnt == CNT_W'(PHASE_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      bp  <= BP_SETUP;
      cnt <= '0;
    end else if (cnt_last) begin
      cnt <= '0;
      unique case (bp)
        BP_SETUP:  bp <= BP_STROBE;
        BP_STROBE: bp <= BP_HOLD;
        default:   bp <= BP_SETUP;
      endcase
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign we_n     = ~(active && is_wr && bp == BP_STROBE);
  assign oe_n     = ~(active && !is_wr && bp == BP_STROBE);
  assign dq_oe    = active && is_wr;
  assign sample   = active && !is_wr && bp == BP_STROBE && cnt_last;
  assign step_end = active && bp == BP_HOLD && cnt_last;
endmodule

// File: rtl/srw_result.sv
module srw_result
  import srw_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic [DATA_W-1:0] got,
  input  logic [DATA_W-1:0] exp,
  input  srw_phase_e        phase,
  input  logic [ADDR_W-1:0] addr,
  output logic              mismatch,
  output logic              fail,
  output logic [2:0]        f_phase,
  output logic [ADDR_W-1:0] f_addr,
  output logic [DATA_W-1:0] f_exp,
  output logic [DATA_W-1:0] f_got
);
  assign mismatch = sample && (got != exp);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      fail    <= 1'b0;
      f_phase <= '0;
      f_addr  <= '0;
      f_exp   <= '0;
      f_got   <= '0;
    end else if (mismatch && !fail) begin
      fail    <= 1'b1;
      f_phase <= phase;
      f_addr  <= addr;
      f_exp   <= exp;
      f_got   <= got;
    end
  end
endmodule

// File: rtl/srw_walk_tester.sv
module srw_walk_tester
  import srw_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int PHASE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_sel_hi,
  output logic              mem_sel_lo_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [2:0]        fail_phase,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_got
);
  localparam int MAX_STEPS = (4 * DATA_W > 2 * (ADDR_W + 1)) ? 4 * DATA_W : 2 * (ADDR_W + 1);
  localparam int IDX_W     = $clog2(MAX_STEPS);
  localparam int CNT_W     = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

  logic              running, done_q, start_go;
  srw_phase_e        ph;
  logic [IDX_W-1:0]  idx;
  logic              s_wr, s_last;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_data;
  srw_sel_e          s_sel;
  logic              sample, step_end, mismatch;

  assign start_go = start && !running;

  srw_step_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rom (
    .phase(ph), .idx(idx), .is_wr(s_wr), .addr(s_addr), .data(s_data),
    .sel(s_sel), .last(s_last)
  );

  srw_bus_engine #(.PHASE_CYC(PHASE_CYC), .CNT_W(CNT_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .active(running), .is_wr(s_wr),
    .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(mem_dq_oe),
    .sample(sample), .step_end(step_end)
  );

  srw_result #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_res (
    .clk(clk), .rst_n(rst_n), .clear(start_go), .sample(sample),
    .got(mem_dq_in), .exp(s_data), .phase(ph), .addr(s_addr),
    .mismatch(mismatch), .fail(fail), .f_phase(fail_phase),
    .f_addr(fail_addr), .f_exp(fail_exp), .f_got(fail_got)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      done_q  <= 1'b0;
      ph      <= PH_WALK_WR;
      idx     <= '0;
    end else if (start_go) begin
      running <= 1'b1;
      done_q  <= 1'b0;
      ph      <= PH_WALK_WR;
      idx     <= '0;
    end else if (running) begin
      if (mismatch) begin
        running <= 1'b0;
        done_q  <= 1'b1;
      end else if (step_end) begin
        if (s_last) begin
          idx <= '0;
          if (ph == PH_BITS) begin
            running <= 1'b0;
            done_q  <= 1'b1;
          end else begin
            ph <= srw_phase_e'(ph + 3'd1);
          end
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end

  always_comb begin
    mem_sel_hi   = 1'b0;
    mem_sel_lo_n = 1'b1;
    if (running) begin
      unique case (s_sel)
        SEL_OFF_HI: begin mem_sel_hi = 1'b1; mem_sel_lo_n = 1'b1; end
        SEL_OFF_LO: begin mem_sel_hi = 1'b0; mem_sel_lo_n = 1'b0; end
        default:    begin mem_sel_hi = 1'b1; mem_sel_lo_n = 1'b0; end
      endcase
    end
  end

  assign mem_addr   = running ? s_addr : '0;
  assign mem_dq_out = s_data;
  assign done       = done_q;
  assign pass       = done_q && !fail;
endmodule

// File: rtl/srw_walk_tester_chk.sv
module srw_walk_tester_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe,
  input logic              mem_sel_hi,
  input logic              mem_sel_lo_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [DATA_W-1:0] fail_got
);
  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  a_r7_write_data_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(fail) && $stable(fail_addr) && $stable(fail_got)));

  a_r10_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  a_r11_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_sel_hi && mem_sel_lo_n && mem_we_n && mem_oe_n));

  a_r12_addr_shape: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_addr));
endmodule

bind srw_walk_tester srw_walk_tester_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/srw_walk_tester_test.sv
`timescale 1ns/1ps
module srw_walk_tester_test;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam int PC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out, ram_q, fail_exp, fail_got;
  logic mem_dq_oe, mem_sel_hi, mem_sel_lo_n, mem_we_n, mem_oe_n;
  logic done, pass, fail;
  logic [2:0] fail_phase;
  logic [AW-1:0] fail_addr;

  always #2.5 clk = ~clk;

  srw_walk_tester #(.ADDR_W(AW), .DATA_W(DW), .PHASE_CYC(PC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(ram_q),
    .mem_sel_hi(mem_sel_hi), .mem_sel_lo_n(mem_sel_lo_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .done(done), .pass(pass),
    .fail(fail), .fail_phase(fail_phase), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_got(fail_got)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural RAM with injectable faults
  logic [7:0] ram [logic [12:0]];
  logic f_short = 1'b0, f_ign_cs1 = 1'b0;
  logic [7:0] f_or = 8'h00, f_and = 8'h00;

  always @(negedge clk) begin
    logic [12:0] ea;
    logic sel;
    logic [7:0] v;
    ea  = f_short ? (mem_addr & ~13'h0020) : mem_addr;
    sel = mem_sel_hi && (f_ign_cs1 || !mem_sel_lo_n);
    if (sel && !mem_we_n && mem_dq_oe) ram[ea] = mem_dq_out;
    v = ram.exists(ea) ? ram[ea] : 8'hFF;
    v = (v | f_or) & ~f_and;
    ram_q <= (sel && !mem_oe_n && mem_we_n) ? v : 8'hFF;
  end

  // Scoreboard
  typedef struct packed {
    logic       wr;
    logic [12:0] addr;
    logic [7:0] data;
    logic       sh;
    logic       sl;
  } op_t;
  op_t exp_q[$];
  int  op_n = 0;

  function automatic logic [12:0] wa(input int k);
    return (k == 0) ? 13'h0 : (13'h1 << (k - 1));
  endfunction

  task automatic push_op(input logic wr, input logic [12:0] a, input logic [7:0] d,
                         input logic sh, input logic sl);
    op_t o;
    o.wr = wr; o.addr = a; o.data = d; o.sh = sh; o.sl = sl;
    exp_q.push_back(o);
  endtask

  task automatic build_plan();
    exp_q.delete();
    op_n = 0;
    for (int k = 0; k < 14; k++) push_op(1, wa(k), 8'h55, 1, 0);
    for (int k = 0; k < 14; k++) begin
      push_op(0, wa(k), 8'h55, 1, 0);
      push_op(1, wa(k), 8'hAA, 1, 0);
    end
    for (int k = 0; k < 14; k++) push_op(0, wa(k), 8'hAA, 1, 0);
    push_op(1, 0, 8'hAA, 1, 0); push_op(1, 0, 8'h55, 1, 1); push_op(0, 0, 8'hAA, 1, 0);
    push_op(1, 0, 8'h55, 1, 0); push_op(1, 0, 8'hAA, 0, 0); push_op(0, 0, 8'h55, 1, 0);
    for (int b = 0; b < 8; b++) begin
      push_op(1, 0, ~(8'h1 << b), 1, 0); push_op(0, 0, ~(8'h1 << b), 1, 0);
      push_op(1, 0, 8'h1 << b, 1, 0);    push_op(0, 0, 8'h1 << b, 1, 0);
    end
  endtask

  function automatic string tag_of(input int n);
    if (n < 14) return "R1";
    if (n < 42) return "R2";
    if (n < 56) return "R3";
    if (n < 59) return "R4";
    if (n < 62) return "R5";
    return "R6";
  endfunction

  logic prev_we = 1'b1, prev_oe = 1'b1, prev_dq_oe = 1'b0;
  int   we_len = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ((prev_we && !mem_we_n) || (prev_oe && !mem_oe_n)) begin
        if (exp_q.size() == 0) begin
          check(0, "R10", "unexpected access", {19'h0, mem_addr}, 0);
        end else begin
          op_t e;
          logic ok;
          e  = exp_q.pop_front();
          ok = (e.wr == !mem_we_n) && (e.addr == mem_addr) &&
               (e.sh == mem_sel_hi) && (e.sl == mem_sel_lo_n) &&
               (!e.wr || e.data == mem_dq_out) && $onehot0(mem_addr);
          check(ok, tag_of(op_n), "access",
                {!mem_we_n, mem_sel_hi, mem_sel_lo_n, mem_addr, mem_dq_out},
                {e.wr, e.sh, e.sl, e.addr, e.data});
          op_n++;
        end
        if (prev_oe && !mem_oe_n)
          check(!prev_dq_oe && !mem_dq_oe, "R8", "bus not released before read", prev_dq_oe, 0);
      end
      if (!mem_we_n) we_len++;
      if (!prev_we && mem_we_n) begin
        check(we_len == PC && mem_dq_oe, "R7", "write pulse width / hold data", we_len, PC);
        we_len = 0;
      end
    end
    prev_we    = mem_we_n;
    prev_oe    = mem_oe_n;
    prev_dq_oe = mem_dq_oe;
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(0, "R10", "watchdog expired", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_seq(input bit mid_start);
    int n;
    ram.delete();
    build_plan();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(!done && !fail && !pass, "R11", "results cleared on start", {done, fail, pass}, 0);
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
      if (mid_start && n == 100) start = 1'b1;
      if (mid_start && n == 101) start = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic expect_fail(input string req, input logic [2:0] ph,
                             input logic [12:0] a, input logic [7:0] e, input logic [7:0] g);
    check(done && fail && !pass, req, "fail flags", {done, fail, pass}, 3'b110);
    check(fail_phase == ph && fail_addr == a && fail_exp == e && fail_got == g, req,
          "fail record", {fail_phase, fail_addr, fail_exp, fail_got},
          {ph, a, e, g});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !pass && !fail && mem_we_n && mem_oe_n && !mem_dq_oe &&
          !mem_sel_hi && mem_sel_lo_n, "R11", "reset state",
          {done, pass, fail, mem_we_n, mem_oe_n, mem_dq_oe, mem_sel_hi, mem_sel_lo_n},
          8'b00011001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Clean run: every access in order, then pass
    run_seq(0);
    check(done && pass && !fail, "R10", "clean pass", {done, pass, fail}, 3'b110);
    check(exp_q.size() == 0, "R10", "all accesses seen", exp_q.size(), 0);

    // Start during a run is ignored: sequence continues unchanged
    run_seq(1);
    check(done && pass && exp_q.size() == 0, "R11", "mid-run start ignored",
          exp_q.size(), 0);

    // Address bit 5 aliased onto zero
    f_short = 1'b1;
    run_seq(0);
    expect_fail("R2", 3'd1, 13'h0020, 8'h55, 8'hAA);
    f_short = 1'b0;

    // Data bit 3 stuck at one
    f_or = 8'h08;
    run_seq(0);
    expect_fail("R9", 3'd1, 13'h0000, 8'h55, 8'h5D);
    f_or = 8'h00;

    // Data bit 7 stuck at zero
    f_and = 8'h80;
    run_seq(0);
    expect_fail("R3", 3'd2, 13'h0000, 8'hAA, 8'h2A);
    f_and = 8'h00;

    // RAM ignores the active-low select
    f_ign_cs1 = 1'b1;
    run_seq(0);
    expect_fail("R4", 3'd3, 13'h0000, 8'hAA, 8'h55);
    f_ign_cs1 = 1'b0;

    // Recovery after a failure
    run_seq(0);
    check(done && pass && !fail, "R5", "clean pass after fault runs", {done, pass, fail}, 3'b110);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule